// File: doc/BRIEF.md
# Sectored Effective Address Generator

This block turns a 16-bit memory-reference instruction into the final 15-bit operand address. The 9-bit in-sector offset is placed either in a relocatable base sector or in the sector that holds the instruction. If the instruction asks for it, the index register is added. The block then follows a chain of indirect words, any number of levels deep, by reading memory over a simple request/acknowledge handshake. When the chain ends, the address is presented for one cycle with a done strobe.

A sequencer raises `start` for one cycle with the instruction, program counter, index value and base-sector number valid. The block is controlled by a three-state machine:

- **ST_IDLE** waits for `start`. It goes to ST_FETCH when the instruction's indirect bit is set and to ST_DONE when it is clear.
- **ST_FETCH** holds one memory read open until it is acknowledged. On the acknowledge it stays in ST_FETCH if the word read has its flag set, and goes to ST_DONE if the flag is clear.
- **ST_DONE** presents the result for one cycle and then returns to ST_IDLE.

From any state, `abort` returns the machine to ST_IDLE. This breaks a chain that never ends.

Top module: `ea_gen`

## Requirements
- R1: After reset, `mem_req` and `ea_valid` are low and the block is idle.
- R2: With instruction bit 9 at 0, the pre-index address is `{base_sector, instr[8:0]}`, so changing `base_sector` relocates the page.
- R3: With instruction bit 9 at 1, the pre-index address is `{pc[14:9], instr[8:0]}`, so the page is the instruction's own sector.
- R4: With instruction bit 14 (index) set, `xreg[14:0]` is added to the pre-index address modulo 2^15. `xreg[15]` has no effect.
- R5: With instruction bit 15 (indirect) set, the first memory read uses the address after indexing. Indexing comes before indirection.
- R6: An indirect word is decoded as follows. Bit 15 set continues the chain. Bit 14 set adds the index value. Bits 13..0 are the zero-extended next address. The block issues exactly one read per level, with no limit on depth.
- R7: `ea_valid` is high for exactly one cycle, with `ea` holding the result and `mem_req` low. For a direct instruction it is high in the cycle after `start` is sampled.
- R8: While `mem_req` is high and not yet acknowledged, it stays high and `mem_addr` stays stable.
- R9: `abort` sends the block to idle. In the next cycle `mem_req` is low, and the aborted operation produces no `ea_valid`.
- R10: `start` is ignored while an operation is in progress.
- R11: The index value is captured when `start` is sampled. Changes to `xreg` later in the chain have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an address computation (sampled in idle only) |
| abort | input | 1 | Return to idle, dropping the current operation |
| instr | input | 16 | Instruction word: 15 indirect, 14 index, 9 sector select, 8..0 offset |
| pc | input | 15 | Address of the current instruction |
| xreg | input | 16 | Index register value |
| base_sector | input | 6 | Sector number used when bit 9 is clear |
| mem_req | output | 1 | Indirect-word read request |
| mem_addr | output | 15 | Read address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` valid with it |
| mem_rdata | input | 16 | Indirect word read from memory |
| ea_valid | output | 1 | One-cycle done strobe |
| ea | output | 15 | Final effective address |

## Verification
Direct instructions are run with the sector bit at both values and with two different base sectors, which separates relocation of the base page from use of the current page. Indexed cases include a sum that wraps past the top of memory and an index value with its top bit set. A decoy word is placed at the unindexed address, so a design that fetches before it indexes produces a visibly wrong address. Indirect chains of one, three and twenty levels, with tag bits inside the chain and varying memory latency, test per-level indexing, the read count and request stability. A self-referencing pointer is aborted mid-chain, and a start pulse with a changed index value is issued during a busy chain; these test idle recovery, the ignoring of `start`, and capture of the index value.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } ea_state_t;

endpackage

// File: rtl/ea_page_sel.sv
module ea_page_sel #(
    parameter int ADDR_W = 15,
    parameter int OFS_W  = 9,
    localparam int SEC_W = ADDR_W - OFS_W
) (
    input  logic [OFS_W-1:0]  offset,
    input  logic              use_cur,
    input  logic [SEC_W-1:0]  cur_sector,
    input  logic [SEC_W-1:0]  base_sector,
    output logic [ADDR_W-1:0] page_addr
);

    always_comb begin
        page_addr = use_cur ? {cur_sector, offset} : {base_sector, offset};
    end

endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [ADDR_W-1:0] xval,
    input  logic              en,
    output logic [ADDR_W-1:0] addr_out
);

    always_comb begin
        addr_out = en ? (addr_in + xval) : addr_in;
    end

endmodule

// File: rtl/ea_ind_decode.sv
module ea_ind_decode #(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 15,
    parameter bit IND_TAG = 1'b1
) (
    input  logic [WORD_W-1:0] word,
    output logic              flag,
    output logic              tag,
    output logic [ADDR_W-1:0] addr
);

    assign flag = word[WORD_W-1];

    generate
        if (IND_TAG) begin : g_tagged
            assign tag  = word[WORD_W-2];
            assign addr = ADDR_W'(word[WORD_W-3:0]);
        end else begin : g_full
            assign tag  = 1'b0;
            assign addr = word[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_gen_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int ADDR_W  = 15,
    parameter int OFS_W   = 9,
    parameter bit IND_TAG = 1'b1,
    localparam int SEC_W  = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [WORD_W-1:0] instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] xreg,
    input  logic [SEC_W-1:0]  base_sector,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea
);

    localparam int FLAG_POS = WORD_W - 1;
    localparam int TAG_POS  = WORD_W - 2;
    localparam int SEL_POS  = OFS_W;

    ea_state_t         state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [ADDR_W-1:0] x_q, x_d;
    logic [ADDR_W-1:0] page_addr, first_addr, ind_addr, chain_addr;
    logic              ind_flag, ind_tag;

    wire unused_bits = ^{instr[TAG_POS-1:SEL_POS+1], pc[OFS_W-1:0],
                         xreg[WORD_W-1:ADDR_W]};

    ea_page_sel #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_page (
        .offset      (instr[OFS_W-1:0]),
        .use_cur     (instr[SEL_POS]),
        .cur_sector  (pc[ADDR_W-1:OFS_W]),
        .base_sector (base_sector),
        .page_addr   (page_addr)
    );

    ea_index_add #(.ADDR_W(ADDR_W)) u_ix_first (
        .addr_in  (page_addr),
        .xval     (xreg[ADDR_W-1:0]),
        .en       (instr[TAG_POS]),
        .addr_out (first_addr)
    );

    ea_ind_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .IND_TAG(IND_TAG)) u_dec (
        .word (mem_rdata),
        .flag (ind_flag),
        .tag  (ind_tag),
        .addr (ind_addr)
    );

    ea_index_add #(.ADDR_W(ADDR_W)) u_ix_chain (
        .addr_in  (ind_addr),
        .xval     (x_q),
        .en       (ind_tag),
        .addr_out (chain_addr)
    );

    // Next-state and datapath selection
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        x_d     = x_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    ptr_d   = first_addr;
                    x_d     = xreg[ADDR_W-1:0];
                    state_d = instr[FLAG_POS] ? ST_FETCH : ST_DONE;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    ptr_d   = chain_addr;
                    state_d = ind_flag ? ST_FETCH : ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (abort) begin
            state_d = ST_IDLE;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pointer and captured index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            x_q   <= '0;
        end else begin
            ptr_q <= ptr_d;
            x_q   <= x_d;
        end
    end

    // Outputs
    always_comb begin
        mem_req  = (state_q == ST_FETCH);
        mem_addr = ptr_q;
        ea_valid = (state_q == ST_DONE);
        ea       = ptr_q;
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |=> !ea_valid);

    // R7
    done_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> !mem_req);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!mem_req && !ea_valid));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !abort && start) |=> $stable(mem_addr));

endmodule

// File: tb/ea_gen_tb_top.sv
module ea_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        abort = 1'b0;
    logic [15:0] instr = '0;
    logic [14:0] pc = '0;
    logic [15:0] xreg = '0;
    logic [5:0]  base_sector = '0;
    logic        mem_req;
    logic [14:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        ea_valid;
    logic [14:0] ea;

    always #5 clk = ~clk;

    ea_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .instr(instr), .pc(pc), .xreg(xreg), .base_sector(base_sector),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .ea_valid(ea_valid), .ea(ea)
    );

    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Sparse memory model
    logic [15:0] mem [int];
    int lat = 0;
    int wcnt = 0;
    int reads = 0;
    bit last_req = 0;
    bit last_ack = 0;
    logic [14:0] last_addr = '0;

    function automatic logic [15:0] mem_get(input logic [14:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        if (rst_n && last_req && !last_ack && mem_req)
            check(mem_addr == last_addr, "R8", "request address moved",
                  int'(mem_addr), int'(last_addr));
        if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt >= lat) begin
                mem_rdata = mem_get(mem_addr);
                mem_ack = 1'b1;
                reads++;
            end else begin
                wcnt++;
            end
        end else begin
            wcnt = 0;
        end
        last_req  = mem_req;
        last_ack  = mem_ack;
        last_addr = mem_addr;
    end

    // Reference model built from the requirements
    function automatic logic [15:0] mk(input bit f, input bit t, input bit s,
                                       input logic [8:0] off);
        return {f, t, 4'b0010, s, off};
    endfunction

    function automatic logic [14:0] ref_ea(input logic [15:0] ins, input logic [14:0] p,
                                           input logic [15:0] x, input logic [5:0] b,
                                           output int nrd);
        logic [14:0] a;
        logic [15:0] w;
        bit          f;
        a = ins[9] ? {p[14:9], ins[8:0]} : {b, ins[8:0]};
        if (ins[14]) a = a + x[14:0];
        f = ins[15];
        nrd = 0;
        while (f && nrd < 1000) begin
            w = mem_get(a);
            nrd++;
            f = w[15];
            a = {1'b0, w[13:0]};
            if (w[14]) a = a + x[14:0];
        end
        return a;
    endfunction

    typedef struct {
        logic [14:0] ea;
        int          nrd;
        int          rd_base;
        string       req;
    } exp_t;

    exp_t sb[$];
    bit   prev_valid = 0;

    // Monitor
    always @(negedge clk) begin
        if (rst_n && ea_valid) begin
            check(!prev_valid, "R7", "strobe longer than one cycle", 1, 0);
            check(!mem_req, "R7", "request high with done", int'(mem_req), 0);
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected done strobe", int'(ea), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(ea == e.ea, e.req, "effective address", int'(ea), int'(e.ea));
                check((reads - e.rd_base) == e.nrd, e.req, "read count",
                      reads - e.rd_base, e.nrd);
            end
        end
        prev_valid = ea_valid;
    end

    // Driver
    task automatic run_op(input logic [15:0] ins, input logic [14:0] p,
                          input logic [15:0] x, input logic [5:0] b, input string req);
        exp_t e;
        int   n;
        e.ea = ref_ea(ins, p, x, b, e.nrd);
        e.req = req;
        @(negedge clk);
        e.rd_base = reads;
        sb.push_back(e);
        instr = ins; pc = p; xreg = x; base_sector = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (e.nrd == 0)
            check(ea_valid == 1'b1, "R7", "direct done latency", int'(ea_valid), 1);
        n = 0;
        while (!ea_valid && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) check(1'b0, req, "no done strobe", 0, 1);
    endtask

    bit wd_hit = 0;
    initial begin
        #1500000;
        wd_hit = 1;
    end

    initial begin : main
        exp_t e;
        // R1
        #1;
        check(mem_req == 1'b0 && ea_valid == 1'b0, "R1", "outputs in reset",
              int'({mem_req, ea_valid}), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_req == 1'b0 && ea_valid == 1'b0, "R1", "outputs after reset",
              int'({mem_req, ea_valid}), 0);

        // R2 base sector, default and relocated
        run_op(mk(0, 0, 0, 9'h1A5), 15'h4321, 16'h0000, 6'h00, "R2");
        run_op(mk(0, 0, 0, 9'h1A5), 15'h4321, 16'h0000, 6'h2B, "R2");
        // R3 current sector
        run_op(mk(0, 0, 1, 9'h033), 15'h5E12, 16'h0000, 6'h2B, "R3");
        // R4 indexing, wrap, top bit of index ignored
        run_op(mk(0, 1, 1, 9'h010), 15'h5E12, 16'h0010, 6'h00, "R4");
        run_op(mk(0, 1, 0, 9'h1FF), 15'h0000, 16'h0003, 6'h3F, "R4");
        run_op(mk(0, 1, 0, 9'h020), 15'h0000, 16'h8001, 6'h01, "R4");

        // R5 index before indirection, decoy at unindexed address
        mem[32'h040] = 16'h2222;
        mem[32'h050] = 16'h1234;
        run_op(mk(1, 1, 0, 9'h040), 15'h0000, 16'h0010, 6'h00, "R5");

        // R6 three levels with tags
        lat = 2;
        mem[32'h200] = 16'h8300;
        mem[32'h300] = 16'hC400;
        mem[32'h420] = 16'h4700;
        run_op(mk(1, 0, 0, 9'h000), 15'h0000, 16'h0020, 6'h01, "R6");

        // R6 twenty-level chain, R8 exercised with longer latency
        lat = 4;
        for (int i = 0; i < 19; i++) mem[32'h1000 + i] = 16'h8000 | 16'(32'h1000 + i + 1);
        mem[32'h1013] = 16'h0ABC;
        run_op(mk(1, 0, 0, 9'h000), 15'h0000, 16'h0000, 6'h08, "R6");

        // R9 abort a self-referencing chain
        lat = 1;
        mem[32'h100] = 16'h8100;
        @(negedge clk);
        instr = mk(1, 0, 0, 9'h100); pc = '0; xreg = '0; base_sector = 6'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        check(mem_req == 1'b1, "R6", "looping chain still reading", int'(mem_req), 1);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(mem_req == 1'b0, "R9", "request after abort", int'(mem_req), 0);
        repeat (5) @(negedge clk);
        check(ea_valid == 1'b0 && mem_req == 1'b0, "R9", "idle after abort",
              int'({mem_req, ea_valid}), 0);
        run_op(mk(0, 0, 1, 9'h0F0), 15'h7E00, 16'h0000, 6'h00, "R9");

        // R10 and R11: start during a busy chain with a changed index value
        lat = 3;
        mem[32'h600] = 16'h8601;
        mem[32'h601] = 16'h4050;
        @(negedge clk);
        e.ea = ref_ea(mk(1, 0, 0, 9'h000), 15'h0000, 16'h0005, 6'h03, e.nrd);
        e.req = "R11";
        e.rd_base = reads;
        sb.push_back(e);
        instr = mk(1, 0, 0, 9'h000); pc = '0; xreg = 16'h0005; base_sector = 6'h03;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        instr = mk(0, 0, 1, 9'h1EE); xreg = 16'h0700; pc = 15'h7FFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(mem_req == 1'b1, "R10", "chain interrupted by start", int'(mem_req), 1);
        begin
            int n = 0;
            while (!ea_valid && n < 5000) begin
                @(negedge clk);
                n++;
            end
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0 && ea_valid == 1'b0, "R10", "extra result from ignored start",
              sb.size(), 0);

        repeat (3) @(negedge clk);
        if (sb.size() != 0) check(1'b0, "R7", "missing results", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    always @(posedge wd_hit) begin
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule